// File: doc/BRIEF.md
# Streaming FFT Frame Sequencer

This block produces the handshake and status strobes that go with a pipelined, continuously streaming N-point FFT. The arithmetic is not here. The block counts accepted input samples into frames of N and follows each frame through three phases: loading, computing, and unloading. While one frame computes, the next one loads and the one before it unloads, so three frames are in flight at once. From this frame tracking it derives the ready-for-data, busy, early-done, done and data-valid signals, together with the index of the sample being accepted and the index of the result being presented.

A synchronous start pulse enables intake. From the next cycle on, ready-for-data stays high and a sample is taken on every cycle that the input valid is high. Frame boundaries are counted in accepted samples, not in clock cycles. A cycle with no input therefore holds the whole pipeline in place, and the output pauses with it. With an uninterrupted input stream, results leave the block at the same rate they arrive, three frame periods later.

Top module: `stream_fft_seq`

## Requirements
- R1: While reset is asserted, all outputs are 0, and they stay 0 until start is seen.
- R2: Ready-for-data rises in the cycle after a start pulse and stays high until reset. A start pulse while ready-for-data is already high has no effect on any output.
- R3: A sample is accepted in a cycle where ready-for-data and the input valid are both high. The input index gives the position (0 to N-1) of the sample accepted in the current cycle and wraps from N-1 to 0. It holds its value in every cycle with no accept, including every cycle before start.
- R4: Early-done is a single-cycle pulse, and done is high in exactly the cycle after each early-done pulse and in no other cycle.
- R5: With one accept per cycle starting at cycle t0, early-done is high at cycles t0+2N-1+kN and done is high at t0+2N+kN, for k = 0, 1, 2, ….
- R6: Busy rises N cycles after the first accepted sample, when the first frame enters computation, and then stays high until reset.
- R7: With one accept per cycle, data-valid first rises exactly 3N cycles after the first accepted sample, with output index 0.
- R8: Once the pipeline is full, data-valid is high in the cycle after each accepted sample and low in the cycle after a cycle with no accept. The output index steps by 1 on each data-valid cycle, wraps from N-1 to 0, and reads 0 whenever data-valid is low.
- R9: A gap in the input stalls the frame phases. After the gap, the input index and the output index resume from where they stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous pulse that enables sample intake |
| in_valid_i | input | 1 | Input sample present this cycle |
| rfd_o | output | 1 | Ready for data |
| busy_o | output | 1 | A frame is in the compute phase |
| edone_o | output | 1 | Early-done, one cycle before done |
| done_o | output | 1 | Frame computation finished |
| dv_o | output | 1 | Result sample presented this cycle |
| in_idx_o | output | $clog2(LEN) | Index of the sample accepted this cycle |
| out_idx_o | output | $clog2(LEN) | Index of the result presented this cycle |

## Verification
Consider a wrong pipeline fill count. It shows as a data-valid edge at the wrong cycle, or as busy rising early. The error is visible no later than the 3N-th cycle of a continuous run. A slipped sample counter moves the early-done and done pulses away from their 2N+kN positions and breaks the output index sequence within one frame. A fault in stall handling shows in the cycle right after a single-cycle input gap: the input index does not hold, data-valid does not drop, or the output index does not resume at the next value.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    // Pipeline occupancy: 0 empty, 1 computing, 2 computing+waiting, 3 unloading
    typedef logic [1:0] sfs_fill_t;
    localparam sfs_fill_t FILL_FULL = 2'd3;

    typedef struct packed {
        logic rfd;
        logic edone;
        logic done;
        logic dv;
    } sfs_flags_t;

endpackage

// File: rtl/sfs_frame_counter.sv
module sfs_frame_counter #(
    parameter int LEN = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    output logic [$clog2(LEN)-1:0]     idx_o,
    output logic                       last_o,
    output logic                       penult_o
);
    localparam int IDX_W = $clog2(LEN);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(LEN - 1);
    localparam logic [IDX_W-1:0] IDX_PENULT = IDX_W'(LEN - 2);

    logic [IDX_W-1:0] idx_d, idx_q;

    // Power-of-two length: natural wrap of the adder closes the frame
    always_comb begin
        idx_d = idx_q;
        if (adv_i) idx_d = idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o    = idx_q;
    assign last_o   = (idx_q == IDX_LAST);
    assign penult_o = (idx_q == IDX_PENULT);

endmodule

// File: rtl/sfs_stage_tracker.sv
module sfs_stage_tracker
    import sfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end_i,
    output logic computing_o,
    output logic unload_next_o
);
    sfs_fill_t fill_d, fill_q;

    // Each completed input frame pushes the pipeline one phase; saturates full
    always_comb begin
        fill_d = fill_q;
        if (frame_end_i && (fill_q != FILL_FULL)) fill_d = fill_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign computing_o   = (fill_q != '0);
    assign unload_next_o = (fill_d == FILL_FULL);

endmodule

// File: rtl/stream_fft_seq.sv
module stream_fft_seq
    import sfs_pkg::*;
#(
    parameter int LEN = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   in_valid_i,
    output logic                   rfd_o,
    output logic                   busy_o,
    output logic                   edone_o,
    output logic                   done_o,
    output logic                   dv_o,
    output logic [$clog2(LEN)-1:0] in_idx_o,
    output logic [$clog2(LEN)-1:0] out_idx_o
);
    localparam int IDX_W = $clog2(LEN);

    sfs_flags_t       flg_d, flg_q;
    logic [IDX_W-1:0] oidx_d, oidx_q;

    logic             accept;
    logic [IDX_W-1:0] in_idx;
    logic             at_last, at_penult;
    logic             computing, unload_next;

    assign accept = flg_q.rfd & in_valid_i;

    sfs_frame_counter #(.LEN(LEN)) u_frame_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (accept),
        .idx_o    (in_idx),
        .last_o   (at_last),
        .penult_o (at_penult)
    );

    sfs_stage_tracker u_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_end_i   (accept & at_last),
        .computing_o   (computing),
        .unload_next_o (unload_next)
    );

    always_comb begin
        flg_d.rfd   = flg_q.rfd | start_i;
        flg_d.edone = accept & at_penult & computing;
        flg_d.done  = flg_q.edone;
        flg_d.dv    = accept & unload_next;
        // Result frame is aligned to the input frame: same position
        oidx_d      = flg_d.dv ? (in_idx + IDX_W'(1)) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q  <= '0;
            oidx_q <= '0;
        end else begin
            flg_q  <= flg_d;
            oidx_q <= oidx_d;
        end
    end

    assign rfd_o     = flg_q.rfd;
    assign busy_o    = computing;
    assign edone_o   = flg_q.edone;
    assign done_o    = flg_q.done;
    assign dv_o      = flg_q.dv;
    assign in_idx_o  = in_idx;
    assign out_idx_o = oidx_q;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int LEN = 512
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   in_valid_i,
    input logic                   rfd_o,
    input logic                   busy_o,
    input logic                   edone_o,
    input logic                   done_o,
    input logic                   dv_o,
    input logic [$clog2(LEN)-1:0] in_idx_o,
    input logic [$clog2(LEN)-1:0] out_idx_o
);
    localparam int IDX_W = $clog2(LEN);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rfd_o && !busy_o && !edone_o && !done_o && !dv_o));

    assert_rfd_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rfd_o |=> rfd_o);

    assert_rfd_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfd_o) |-> $past(start_i));

    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfd_o && in_valid_i) |=> $stable(in_idx_o));

    assert_edone_then_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edone_o |=> (done_o && !edone_o));

    assert_done_after_edone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(edone_o));

    assert_busy_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> busy_o);

    assert_dv_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |-> busy_o);

    assert_oidx_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dv_o |-> (out_idx_o == '0));

    assert_oidx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_o && $past(dv_o)) |-> (out_idx_o == IDX_W'($past(out_idx_o) + 1'b1)));

    assert_dv_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |-> $past(rfd_o && in_valid_i));

endmodule

bind stream_fft_seq sfs_checker #(.LEN(LEN)) u_sfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .rfd_o      (rfd_o),
    .busy_o     (busy_o),
    .edone_o    (edone_o),
    .done_o     (done_o),
    .dv_o       (dv_o),
    .in_idx_o   (in_idx_o),
    .out_idx_o  (out_idx_o)
);

// File: tb/test_stream_fft_seq.sv
module test_stream_fft_seq;
    localparam int LEN   = 16;
    localparam int IDX_W = $clog2(LEN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic in_valid_i = 1'b0;
    logic rfd_o, busy_o, edone_o, done_o, dv_o;
    logic [IDX_W-1:0] in_idx_o, out_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    stream_fft_seq #(.LEN(LEN)) i_stream_fft_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .rfd_o(rfd_o), .busy_o(busy_o), .edone_o(edone_o), .done_o(done_o),
        .dv_o(dv_o), .in_idx_o(in_idx_o), .out_idx_o(out_idx_o)
    );

    // Timeline for continuous input, cycle k counted from the first accept.
    // Fields: k[19:12], {busy,edone,done,dv}[11:8], out_idx[7:4], in_idx[3:0]
    localparam int NV = 16;
    localparam logic [19:0] VEC [0:NV-1] = '{
        20'h00000,  // k=0   idle, first sample index 0 (R3)
        20'h0F00F,  // k=15  last sample of frame 0, not yet busy (R6)
        20'h10800,  // k=16  busy rises at N (R6)
        20'h1E80E,  // k=30  no early-done yet (R5)
        20'h1FC0F,  // k=31  early-done at 2N-1 (R4 R5)
        20'h20A00,  // k=32  done at 2N (R4 R5)
        20'h21801,  // k=33
        20'h2E80E,  // k=46
        20'h2FC0F,  // k=47  early-done period N, dv still low (R5 R7)
        20'h30B00,  // k=48  dv rises at 3N with index 0 (R7)
        20'h31911,  // k=49  output index steps (R8)
        20'h3E9EE,  // k=62
        20'h3FDFF,  // k=63  early-done again (R5)
        20'h40B00,  // k=64  output index wraps to 0 (R8)
        20'h41911,  // k=65
        20'h00000   // unused tail (k=0 is behind, skipped)
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] snap();
        return {8'd0, busy_o, edone_o, done_o, dv_o, out_idx_o, in_idx_o};
    endfunction

    initial begin
        #200000;
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        // R1: outputs cleared in reset
        #2;
        chk("R1 reset outputs", {rfd_o, busy_o, edone_o, done_o, dv_o, in_idx_o, out_idx_o}, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_valid_i = 1'b1;  // valid before start must be ignored (R3)
        repeat (4) @(negedge clk);
        chk("R3 no accept before start", {rfd_o, in_idx_o}, '0);
        chk("R1 idle until start", {busy_o, dv_o, edone_o, done_o}, '0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 rfd after start", rfd_o, 1);
        k = 0;
        for (int v = 0; v < NV - 1; v++) begin
            while (k < int'(VEC[v][19:12])) begin
                @(negedge clk);
                k++;
            end
            chk($sformatf("R3 R5 R6 R7 R8 timeline k=%0d", k), snap(), {8'd0, VEC[v][11:0]});
        end
        while (k < 70) begin @(negedge clk); k++; end
        chk("R8 before gap", snap(), {8'd0, 4'h9, 4'h6, 4'h6});
        in_valid_i = 1'b0;
        start_i = 1'b1;  // start while running: no effect (R2)
        @(negedge clk); k++;
        chk("R9 gap stalls", snap(), {8'd0, 4'h8, 4'h0, 4'h6});
        chk("R2 start while running", rfd_o, 1);
        in_valid_i = 1'b1;
        start_i = 1'b0;
        @(negedge clk); k++;
        chk("R9 resume after gap", snap(), {8'd0, 4'h9, 4'h7, 4'h7});
        // mid-run reset
        rst_n = 1'b0;
        #1;
        chk("R1 async reset mid-run", {rfd_o, busy_o, edone_o, done_o, dv_o, in_idx_o, out_idx_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 ignored after reset", {rfd_o, in_idx_o}, '0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 restart", {rfd_o, in_idx_o}, {1'b1, 4'h0});
        @(negedge clk);
        chk("R3 counting resumes", in_idx_o, 1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule